// File: doc/BRIEF.md
# USB Device Event Interrupt Unit

This block gathers the bus events of a USB device controller into one flag register and gives software a matching enable register. Start-of-frame, end-of-reset, end-of-resume and upstream-resume detections arrive as one-cycle pulses from the protocol logic. Suspend and wake-up are produced inside the block from a single bus-idle level: a cycle counter raises suspend after a long idle stretch, and the first active cycle after idle raises wake-up.

Software reads both registers over a small synchronous register port and writes the enables. It acknowledges events by writing zero to the flag bits it wants to clear. Writing one to a flag bit does nothing, so software can never create an event. One registered interrupt line combines every flag that has its enable set, and a global-enable input from the CPU side gates it.

Top module: `usb_evt_irq`

## Requirements
- R1: After synchronous reset, both registers read 0x00 and `irq` is low.
- R2: Each event sets its own flag on the clock edge that samples it, whether or not its enable bit is set. The flag bits are: suspend bit 0, start-of-frame bit 2, end-of-reset bit 3, wake-up bit 4, end-of-resume bit 5, upstream-resume bit 6.
- R3: A write to the flag register (`reg_addr`=0) clears every flag whose data bit is 0. Flags whose data bit is 1 keep their value, so a write can never set a flag.
- R4: If a hardware event and a software clear hit the same flag in the same cycle, the flag ends up set.
- R5: The enable register (`reg_addr`=1) uses the same bit positions as the flag register and is writable. Bits 1 and 7 of both registers always read 0.
- R6: The suspend flag becomes visible after the edge that samples the (IDLE_CYCLES+1)-th consecutive cycle with `bus_idle` high, and not before.
- R7: Within one unbroken idle period, the suspend flag is raised at most once. After software clears it, the flag stays clear while the bus stays idle.
- R8: Any cycle with `bus_idle` low restarts the idle count from zero.
- R9: The wake-up flag is set by the first cycle with `bus_idle` low that follows a cycle with `bus_idle` high. A bus that stays active does not set it again.
- R10: `irq` is a register. At each edge it loads the global enable ANDed with the OR over all bits of (flag AND enable), so it follows the register state with one cycle of latency.
- R11: `reg_rdata` shows the flag register when `reg_addr`=0 and the enable register when `reg_addr`=1, with no added latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_idle | input | 1 | High while the bus lines sit in the idle state |
| sof_pulse | input | 1 | One-cycle start-of-frame detection |
| eor_pulse | input | 1 | One-cycle end-of-reset detection |
| eorsm_pulse | input | 1 | One-cycle end-of-resume detection |
| uprsm_pulse | input | 1 | One-cycle upstream-resume detection |
| glb_ie | input | 1 | Global interrupt enable from the CPU side |
| reg_addr | input | 1 | Register select: 0 flags, 1 enables |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| irq | output | 1 | Registered combined interrupt |

## Verification
The properties assume that event pulses come from synchronous logic and last one cycle, and that a register write is a one-cycle strobe with stable address and data. They also treat `bus_idle` as already synchronised to `clk`. The stimulus drives every input on the falling edge and holds it for whole cycles, so each rising edge sees clean single-cycle values. The bench sets the idle threshold to a small value so that suspend, its single-shot behaviour and the counter restart all fall within a short run.

// File: rtl/usb_evt_pkg.sv
package usb_evt_pkg;

    localparam int REG_W = 8;

    localparam int B_SUSP  = 0;
    localparam int B_SOF   = 2;
    localparam int B_EOR   = 3;
    localparam int B_WAKE  = 4;
    localparam int B_EORSM = 5;
    localparam int B_UPRSM = 6;

    // bits that hold real state; the rest read as zero
    localparam logic [REG_W-1:0] IMPL_MASK = 8'h7D;

    typedef struct packed {
        logic uprsm;
        logic eorsm;
        logic wake;
        logic eor;
        logic sof;
        logic susp;
    } evt_t;

    function automatic logic [REG_W-1:0] evt_to_vec(input evt_t e);
        logic [REG_W-1:0] v;
        v          = '0;
        v[B_SUSP]  = e.susp;
        v[B_SOF]   = e.sof;
        v[B_EOR]   = e.eor;
        v[B_WAKE]  = e.wake;
        v[B_EORSM] = e.eorsm;
        v[B_UPRSM] = e.uprsm;
        return v;
    endfunction

endpackage

// File: rtl/usb_idle_timer.sv
module usb_idle_timer #(
    parameter int IDLE_CYCLES = 48000
) (
    input  logic clk,
    input  logic rst,
    input  logic bus_idle,
    output logic susp_evt,
    output logic wake_evt
);
    localparam int CW = $clog2(IDLE_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(IDLE_CYCLES);

    logic [CW-1:0] cnt_q;
    logic          fired_q;
    logic          idle_prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q       <= '0;
            fired_q     <= 1'b0;
            idle_prev_q <= 1'b0;
        end else begin
            idle_prev_q <= bus_idle;
            if (!bus_idle) begin
                cnt_q   <= '0;
                fired_q <= 1'b0;
            end else begin
                if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
                if (susp_evt) fired_q <= 1'b1;
            end
        end
    end

    always_comb begin
        susp_evt = bus_idle && (cnt_q == LIMIT) && !fired_q;
        wake_evt = !bus_idle && idle_prev_q;
    end

endmodule

// File: rtl/usb_evt_flags.sv
module usb_evt_flags
    import usb_evt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [REG_W-1:0] set_vec,
    input  logic [REG_W-1:0] clr_vec,
    output logic [REG_W-1:0] flags
);
    for (genvar i = 0; i < REG_W; i++) begin : g_bit
        if (IMPL_MASK[i]) begin : g_impl
            logic f_q;
            always_ff @(posedge clk) begin
                if (rst)             f_q <= 1'b0;
                else if (set_vec[i]) f_q <= 1'b1;
                else if (clr_vec[i]) f_q <= 1'b0;
            end
            assign flags[i] = f_q;
        end else begin : g_rsv
            assign flags[i] = 1'b0;
        end
    end

endmodule

// File: rtl/usb_evt_irqgen.sv
module usb_evt_irqgen
    import usb_evt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [REG_W-1:0] flags,
    input  logic [REG_W-1:0] enables,
    input  logic             glb_ie,
    output logic             irq
);
    logic pend;

    always_comb pend = glb_ie && (|(flags & enables));

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= pend;
    end

endmodule

// File: rtl/usb_evt_irq.sv
module usb_evt_irq
    import usb_evt_pkg::*;
#(
    parameter int IDLE_CYCLES = 48000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_idle,
    input  logic             sof_pulse,
    input  logic             eor_pulse,
    input  logic             eorsm_pulse,
    input  logic             uprsm_pulse,
    input  logic             glb_ie,
    input  logic             reg_addr,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             irq
);
    logic             susp_evt;
    logic             wake_evt;
    evt_t             evt;
    logic [REG_W-1:0] set_vec;
    logic [REG_W-1:0] clr_vec;
    logic [REG_W-1:0] flags_q;
    logic [REG_W-1:0] en_q;

    usb_idle_timer #(.IDLE_CYCLES(IDLE_CYCLES)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .bus_idle (bus_idle),
        .susp_evt (susp_evt),
        .wake_evt (wake_evt)
    );

    always_comb begin
        evt.susp  = susp_evt;
        evt.sof   = sof_pulse;
        evt.eor   = eor_pulse;
        evt.wake  = wake_evt;
        evt.eorsm = eorsm_pulse;
        evt.uprsm = uprsm_pulse;
        set_vec   = evt_to_vec(evt);
        clr_vec   = (reg_wr && !reg_addr) ? (~reg_wdata & IMPL_MASK) : '0;
    end

    usb_evt_flags u_flags (
        .clk     (clk),
        .rst     (rst),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .flags   (flags_q)
    );

    always_ff @(posedge clk) begin
        if (rst)                    en_q <= '0;
        else if (reg_wr && reg_addr) en_q <= reg_wdata & IMPL_MASK;
    end

    always_comb reg_rdata = reg_addr ? en_q : flags_q;

    usb_evt_irqgen u_irq (
        .clk     (clk),
        .rst     (rst),
        .flags   (flags_q),
        .enables (en_q),
        .glb_ie  (glb_ie),
        .irq     (irq)
    );

endmodule

// File: rtl/usb_evt_irq_chk.sv
module usb_evt_irq_chk (
    input logic       clk,
    input logic       rst,
    input logic       sof_pulse,
    input logic       reg_wr,
    input logic       reg_addr,
    input logic       wdata_sof,
    input logic       glb_ie,
    input logic [7:0] flags_q,
    input logic [7:0] en_q,
    input logic       irq
);
    // R2: a start-of-frame pulse always lands in bit 2
    p_sof_sets_r2: assert property (@(posedge clk) disable iff (rst)
        sof_pulse |=> flags_q[2]);

    // R3: a flag write without an event cannot raise the flag
    p_one_no_set_r3: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && !reg_addr && !sof_pulse && !flags_q[2]) |=> !flags_q[2]);

    // R3: a zero in the written data clears the flag
    p_zero_clears_r3: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && !reg_addr && !wdata_sof && !sof_pulse) |=> !flags_q[2]);

    // R4: event beats a simultaneous clear
    p_set_wins_r4: assert property (@(posedge clk) disable iff (rst)
        (sof_pulse && reg_wr && !reg_addr && !wdata_sof) |=> flags_q[2]);

    // R10: global enable low forces the line low next cycle
    p_irq_gate_r10: assert property (@(posedge clk) disable iff (rst)
        !glb_ie |=> !irq);

    // R10: no enabled flag means no interrupt next cycle
    p_irq_pair_r10: assert property (@(posedge clk) disable iff (rst)
        ((flags_q & en_q) == 8'h00) |=> !irq);

endmodule

bind usb_evt_irq usb_evt_irq_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .sof_pulse (sof_pulse),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .wdata_sof (reg_wdata[2]),
    .glb_ie    (glb_ie),
    .flags_q   (flags_q),
    .en_q      (en_q),
    .irq       (irq)
);

// File: tb/test_usb_evt_irq.sv
module test_usb_evt_irq;

    localparam int IDLE = 24;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_idle = 1'b0;
    logic       sof_pulse = 1'b0, eor_pulse = 1'b0, eorsm_pulse = 1'b0, uprsm_pulse = 1'b0;
    logic       glb_ie = 1'b0;
    logic       reg_addr = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq;

    always #4 clk = ~clk;

    usb_evt_irq #(.IDLE_CYCLES(IDLE)) i_usb_evt_irq (
        .clk(clk), .rst(rst), .bus_idle(bus_idle),
        .sof_pulse(sof_pulse), .eor_pulse(eor_pulse),
        .eorsm_pulse(eorsm_pulse), .uprsm_pulse(uprsm_pulse),
        .glb_ie(glb_ie), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    typedef struct {
        int         due;
        bit         is_irq;
        logic [7:0] exp;
        string      tag;
    } item_t;

    item_t q[$];
    int    cyc = 0;
    int    total = 0;
    int    bad = 0;
    bit    done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: pops expected items when they fall due
    always @(negedge clk) begin
        #1;
        while (q.size() > 0 && q[0].due <= cyc) begin
            item_t it;
            logic [7:0] act;
            it = q.pop_front();
            act = it.is_irq ? {7'b0, irq} : reg_rdata;
            total++;
            if (act !== it.exp) begin
                bad++;
                $display("FAIL %s actual=%02h expected=%02h", it.tag, act, it.exp);
            end
        end
    end

    task automatic step();
        @(negedge clk);
    endtask

    task automatic check_reg(input logic a, input logic [7:0] e, input string tag);
        item_t it;
        reg_addr = a;
        it.due = cyc; it.is_irq = 1'b0; it.exp = e; it.tag = tag;
        q.push_back(it);
        step();
    endtask

    task automatic check_irq(input logic e, input string tag);
        item_t it;
        it.due = cyc; it.is_irq = 1'b1; it.exp = {7'b0, e}; it.tag = tag;
        q.push_back(it);
        step();
    endtask

    task automatic reg_write(input logic a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        step();
        reg_wr = 1'b0;
    endtask

    task automatic pulse(input logic up, input logic em, input logic er, input logic sf);
        {uprsm_pulse, eorsm_pulse, eor_pulse, sof_pulse} = {up, em, er, sf};
        step();
        {uprsm_pulse, eorsm_pulse, eor_pulse, sof_pulse} = 4'b0;
    endtask

    initial begin
        repeat (3) step();
        rst = 1'b0;
        check_reg(1'b0, 8'h00, "R1 flags after reset");
        check_reg(1'b1, 8'h00, "R1 enables after reset");
        check_irq(1'b0, "R1 irq after reset");

        pulse(0, 0, 0, 1);
        check_reg(1'b0, 8'h04, "R2 sof sets bit2 with enable off");
        check_irq(1'b0, "R10 no irq with enables off");

        reg_write(1'b1, 8'hFF);
        check_reg(1'b1, 8'h7D, "R5 reserved enable bits read zero");
        check_irq(1'b0, "R10 global enable off");
        glb_ie = 1'b1;
        step();
        check_irq(1'b1, "R10 irq one cycle after global enable");

        reg_write(1'b0, 8'hFF);
        check_reg(1'b0, 8'h04, "R3 writing ones leaves flags");
        reg_write(1'b0, 8'hFB);
        check_reg(1'b0, 8'h00, "R3 writing zero clears bit2");
        check_irq(1'b0, "R10 irq drops after clear");

        pulse(1, 1, 1, 0);
        check_reg(1'b0, 8'h68, "R2 eor bit3 eorsm bit5 uprsm bit6");
        check_irq(1'b1, "R10 irq from resume flags");
        reg_write(1'b0, 8'hDF);
        check_reg(1'b0, 8'h48, "R3 clear only bit5");

        reg_write(1'b1, 8'h01);
        step();
        check_irq(1'b0, "R10 enable gating");

        // R4: sof event and clear-all write in the same cycle
        sof_pulse = 1'b1; reg_addr = 1'b0; reg_wdata = 8'h00; reg_wr = 1'b1;
        step();
        sof_pulse = 1'b0; reg_wr = 1'b0;
        check_reg(1'b0, 8'h04, "R4 set wins over clear");

        reg_write(1'b1, 8'h7D);
        reg_write(1'b0, 8'h00);

        bus_idle = 1'b1;
        repeat (IDLE) step();
        check_reg(1'b0, 8'h00, "R6 no suspend at threshold");
        check_reg(1'b0, 8'h01, "R6 suspend after threshold");
        check_irq(1'b1, "R10 irq from suspend");

        reg_write(1'b0, 8'hFE);
        repeat (IDLE + 5) step();
        check_reg(1'b0, 8'h00, "R7 suspend once per idle period");

        bus_idle = 1'b0;
        step();
        check_reg(1'b0, 8'h10, "R9 wake on leaving idle");
        reg_write(1'b0, 8'h00);
        check_reg(1'b0, 8'h00, "R9 no wake while active");

        bus_idle = 1'b1;
        repeat (IDLE - 5) step();
        bus_idle = 1'b0;
        step();
        bus_idle = 1'b1;
        repeat (IDLE) step();
        check_reg(1'b0, 8'h10, "R8 count restarted by active cycle");
        check_reg(1'b0, 8'h11, "R8 suspend after full restart");
        check_reg(1'b1, 8'h7D, "R11 read mux selects enables");

        glb_ie = 1'b0;
        step();
        check_irq(1'b0, "R10 global enable cleared");

        repeat (2) step();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule